// File: doc/BRIEF.md
# Descriptor-Driven Two-Step DMA Channel

This block is one DMA channel that takes its work from a small table of transfer descriptors. Software loads the table through a register write port. A start pulse, or an external request line when request-triggered mode is selected, makes the channel read the descriptor at its current table position. For each descriptor it reads a 32-byte source burst into an internal staging buffer. It then writes that buffer to the destination as four separate 8-byte beats. The data path is 64 bits wide.

Each descriptor carries control flags, a byte length and two 32-byte-aligned pointers. The flags are valid, wrap, last, interrupt, continuous, source increment and destination increment. Descriptors without the last flag chain to the next table entry. A wrapped entry chains back to entry 0, so a single wrapped entry points at itself. A continuous descriptor keeps its valid flag after it has run, so the same transfer can be started again without reloading the table. Sticky interrupt and error flags report completion and misuse. One input clears both flags.

The master port carries one beat per handshake: a beat completes in a cycle where `m_valid_o` and `m_ready_i` are both high. While `m_valid_o` is high and `m_ready_i` is low, the channel holds the address, direction and write data unchanged and keeps `m_valid_o` high. On a read beat, the memory presents `m_rdata_i` in the handshake cycle, and the channel captures it on that clock edge. The memory may stall for any number of cycles.

Top module: `dma_desc_chan`

## Requirements
- R1: The control field of a descriptor is coded as follows: bit 0 valid, bit 1 wrap, bit 2 last, bit 3 interrupt, bit 4 continuous, bit 5 source increment, bit 6 destination increment. A trigger that finds the current descriptor not valid sets `err_o` and makes no bus access.
- R2: After a wrapped descriptor is processed, the next descriptor comes from table entry 0. Without wrap, the next descriptor comes from the following entry.
- R3: After a descriptor with the interrupt flag is processed, `irq_o` is set and stays set until `stat_clr_i` is pulsed. `stat_clr_i` also clears `err_o`.
- R4: After a descriptor with the last flag is processed, the channel returns to idle (`busy_o` low). The next trigger then processes the following table entry, or entry 0 if the finished descriptor was wrapped.
- R5: A non-continuous descriptor has its valid flag cleared once it is processed, so a second trigger on it raises `err_o`. A continuous descriptor stays valid and runs again on each trigger.
- R6: Each burst is four 8-byte read beats into the staging buffer, followed by four 8-byte write beats. No write beat starts before all reads of its burst are done.
- R7: With source increment, read beat i of a burst uses address src+8*i, and the source pointer advances by 32 after each burst. Without it, every read uses the source pointer unchanged.
- R8: With destination increment, the destination pointer advances by 8 after each write beat. Without it, every write goes to the same address.
- R9: A descriptor moves length/32 bursts; the low 5 bits of the length are ignored. A length below 32 makes no bus access but still completes the descriptor (flags, interrupt, chaining).
- R10: A trigger that arrives while the channel is busy is ignored.
- R11: With `trig_mode_i` low, `start_i` triggers the channel and `ext_req_i` is ignored. With `trig_mode_i` high, `ext_req_i` triggers it and `start_i` is ignored.
- R12: While `m_valid_o` is high and `m_ready_i` is low, `m_valid_o`, `m_write_o`, `m_addr_o` and `m_wdata_o` hold their values into the next cycle.
- R13: After reset the channel is idle, with `busy_o`, `irq_o`, `err_o` and `m_valid_o` low, and every table entry is not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | IDX_W | Table entry to write |
| cfg_ctrl | input | 7 | Control flags (coding in R1) |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_src | input | ADDR_W | Source pointer (32-byte aligned) |
| cfg_dst | input | ADDR_W | Destination pointer (32-byte aligned) |
| start_i | input | 1 | Start command pulse |
| trig_mode_i | input | 1 | 1 selects the external request as trigger |
| ext_req_i | input | 1 | External transfer request |
| stat_clr_i | input | 1 | Clear sticky irq and error flags |
| m_valid_o | output | 1 | Master beat valid |
| m_ready_i | input | 1 | Master beat accepted |
| m_write_o | output | 1 | 1 = write beat, 0 = read beat |
| m_addr_o | output | ADDR_W | Beat byte address |
| m_wdata_o | output | DATA_W | Write data |
| m_rdata_i | input | DATA_W | Read data, valid in the handshake cycle |
| busy_o | output | 1 | Channel is working on a descriptor |
| irq_o | output | 1 | Sticky descriptor-done interrupt |
| err_o | output | 1 | Sticky invalid-descriptor error |

## Verification
A wrong beat counter or pointer shows at the ports within one transfer. It appears as a wrong number of handshakes or as data landing at the wrong destination word, and both are checked as soon as `busy_o` falls. A wrong table index or a valid flag left in the wrong state stays hidden until the next trigger. That trigger then runs the wrong entry or raises `err_o`, so the bench always triggers the same entry a second time. Under random back-pressure, an address or data change during a stall would corrupt destination contents within the same burst.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int CTRL_W = 7;
  localparam int B_VALID = 0;
  localparam int B_WRAP  = 1;
  localparam int B_LAST  = 2;
  localparam int B_INTR  = 3;
  localparam int B_CONT  = 4;
  localparam int B_SINC  = 5;
  localparam int B_DINC  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } chan_state_e;
endpackage

// File: rtl/dma_desc_table.sv
module dma_desc_table
  import dma_chan_pkg::*;
#(
  parameter int NUM_DESC = 4,
  parameter int ADDR_W   = 32,
  parameter int LEN_W    = 12,
  localparam int IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [CTRL_W-1:0] wr_ctrl_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [ADDR_W-1:0] wr_src_i,
  input  logic [ADDR_W-1:0] wr_dst_i,
  input  logic              clr_en_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [CTRL_W-1:0] rd_ctrl_o,
  output logic [LEN_W-1:0]  rd_len_o,
  output logic [ADDR_W-1:0] rd_src_o,
  output logic [ADDR_W-1:0] rd_dst_o
);
  logic [CTRL_W-1:0] ctrl_q [NUM_DESC];
  logic [LEN_W-1:0]  len_q  [NUM_DESC];
  logic [ADDR_W-1:0] src_q  [NUM_DESC];
  logic [ADDR_W-1:0] dst_q  [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_entry
    wire hit_wr  = wr_en_i  && (wr_idx_i  == IDX_W'(g));
    wire hit_clr = clr_en_i && (clr_idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q[g] <= '0;
        len_q[g]  <= '0;
        src_q[g]  <= '0;
        dst_q[g]  <= '0;
      end else if (hit_wr) begin
        ctrl_q[g] <= wr_ctrl_i;
        len_q[g]  <= wr_len_i;
        src_q[g]  <= wr_src_i;
        dst_q[g]  <= wr_dst_i;
      end else if (hit_clr) begin
        ctrl_q[g][B_VALID] <= 1'b0;
      end
    end
  end

  assign rd_ctrl_o = ctrl_q[rd_idx_i];
  assign rd_len_o  = len_q[rd_idx_i];
  assign rd_src_o  = src_q[rd_idx_i];
  assign rd_dst_o  = dst_q[rd_idx_i];

  // R5
  valid_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && !wr_en_i) |=> !ctrl_q[$past(clr_idx_i)][B_VALID]);
endmodule

// File: rtl/dma_stage_buf.sv
module dma_stage_buf #(
  parameter int BEATS  = 4,
  parameter int DATA_W = 64,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [BEAT_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [BEAT_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] slot_q [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_idx_i == BEAT_W'(g))) slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int NUM_DESC  = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int LEN_W     = 12,
  parameter int SRC_BYTES = 32,
  localparam int IDX_W       = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int BEAT_BYTES  = DATA_W / 8,
  localparam int BEATS       = SRC_BYTES / BEAT_BYTES,
  localparam int BEAT_W      = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int BURST_SHIFT = $clog2(SRC_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              stat_clr_i,
  input  logic [CTRL_W-1:0] d_ctrl_i,
  input  logic [LEN_W-1:0]  d_len_i,
  input  logic [ADDR_W-1:0] d_src_i,
  input  logic [ADDR_W-1:0] d_dst_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              clr_en_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic              m_write_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic              buf_wr_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              err_o
);
  chan_state_e       state_q;
  logic [IDX_W-1:0]  idx_q, nxt_idx;
  logic [ADDR_W-1:0] src_q, dst_q, rd_addr;
  logic [LEN_W-1:0]  bursts_q, desc_bursts;
  logic [BEAT_W-1:0] beat_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              irq_q, err_q;
  logic              hs, last_beat;

  assign hs          = m_valid_o && m_ready_i;
  assign last_beat   = (beat_q == BEAT_W'(BEATS - 1));
  assign desc_bursts = d_len_i >> BURST_SHIFT;

  always_comb begin
    if (ctrl_q[B_WRAP] || (idx_q == IDX_W'(NUM_DESC - 1))) nxt_idx = '0;
    else nxt_idx = idx_q + IDX_W'(1);
  end

  always_comb begin
    rd_addr = src_q;
    if (ctrl_q[B_SINC]) rd_addr = src_q + ADDR_W'(beat_q) * ADDR_W'(BEAT_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      bursts_q <= '0;
      beat_q   <= '0;
      ctrl_q   <= '0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (stat_clr_i) begin
        irq_q <= 1'b0;
        err_q <= 1'b0;
      end
      case (state_q)
        ST_IDLE: if (trig_i) state_q <= ST_FETCH;
        ST_FETCH: begin
          if (!d_ctrl_i[B_VALID]) begin
            err_q   <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            ctrl_q   <= d_ctrl_i;
            src_q    <= d_src_i;
            dst_q    <= d_dst_i;
            bursts_q <= desc_bursts;
            beat_q   <= '0;
            state_q  <= (desc_bursts == '0) ? ST_DONE : ST_READ;
          end
        end
        ST_READ: if (hs) begin
          beat_q <= beat_q + BEAT_W'(1);
          if (last_beat) begin
            beat_q  <= '0;
            state_q <= ST_WRITE;
            if (ctrl_q[B_SINC]) src_q <= src_q + ADDR_W'(SRC_BYTES);
          end
        end
        ST_WRITE: if (hs) begin
          beat_q <= beat_q + BEAT_W'(1);
          if (ctrl_q[B_DINC]) dst_q <= dst_q + ADDR_W'(BEAT_BYTES);
          if (last_beat) begin
            beat_q   <= '0;
            bursts_q <= bursts_q - LEN_W'(1);
            state_q  <= (bursts_q == LEN_W'(1)) ? ST_DONE : ST_READ;
          end
        end
        ST_DONE: begin
          if (ctrl_q[B_INTR]) irq_q <= 1'b1;
          idx_q   <= nxt_idx;
          state_q <= ctrl_q[B_LAST] ? ST_IDLE : ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o     = idx_q;
  assign clr_en_o  = (state_q == ST_DONE) && !ctrl_q[B_CONT];
  assign m_valid_o = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign m_write_o = (state_q == ST_WRITE);
  assign m_addr_o  = (state_q == ST_WRITE) ? dst_q : rd_addr;
  assign buf_wr_o  = (state_q == ST_READ) && hs;
  assign beat_o    = beat_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign irq_o     = irq_q;
  assign err_o     = err_q;

  // R12
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_addr_o) && $stable(m_write_o)));
  // R1
  invalid_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && !d_ctrl_i[B_VALID]) |=> (err_o && !busy_o && !m_valid_o));
  // R3
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !stat_clr_i) |=> irq_o);
  // R4
  last_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && ctrl_q[B_LAST]) |=> !busy_o);
  // R2
  wrap_to_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE && ctrl_q[B_WRAP]) |=> (idx_o == '0));
  // R6
  write_after_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(m_write_o)) |-> ($past(hs) && $past(last_beat)));
endmodule

// File: rtl/dma_desc_chan.sv
module dma_desc_chan
  import dma_chan_pkg::*;
#(
  parameter int NUM_DESC  = 4,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int LEN_W     = 12,
  parameter int SRC_BYTES = 32,
  localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int BEATS    = SRC_BYTES / (DATA_W / 8),
  localparam int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [CTRL_W-1:0] cfg_ctrl,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [ADDR_W-1:0] cfg_src,
  input  logic [ADDR_W-1:0] cfg_dst,
  input  logic              start_i,
  input  logic              trig_mode_i,
  input  logic              ext_req_i,
  input  logic              stat_clr_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic              m_write_o,
  output logic [ADDR_W-1:0] m_addr_o,
  output logic [DATA_W-1:0] m_wdata_o,
  input  logic [DATA_W-1:0] m_rdata_i,
  output logic              busy_o,
  output logic              irq_o,
  output logic              err_o
);
  logic [CTRL_W-1:0] d_ctrl;
  logic [LEN_W-1:0]  d_len;
  logic [ADDR_W-1:0] d_src, d_dst;
  logic [IDX_W-1:0]  cur_idx;
  logic              clr_en, buf_wr, trig;
  logic [BEAT_W-1:0] beat;

  assign trig = trig_mode_i ? ext_req_i : start_i;

  dma_desc_table #(
    .NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) table_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(cfg_we), .wr_idx_i(cfg_idx), .wr_ctrl_i(cfg_ctrl),
    .wr_len_i(cfg_len), .wr_src_i(cfg_src), .wr_dst_i(cfg_dst),
    .clr_en_i(clr_en), .clr_idx_i(cur_idx), .rd_idx_i(cur_idx),
    .rd_ctrl_o(d_ctrl), .rd_len_o(d_len), .rd_src_o(d_src), .rd_dst_o(d_dst)
  );

  dma_chan_engine #(
    .NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .LEN_W(LEN_W), .SRC_BYTES(SRC_BYTES)
  ) engine_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .stat_clr_i(stat_clr_i),
    .d_ctrl_i(d_ctrl), .d_len_i(d_len), .d_src_i(d_src), .d_dst_i(d_dst),
    .idx_o(cur_idx), .clr_en_o(clr_en),
    .m_valid_o(m_valid_o), .m_ready_i(m_ready_i), .m_write_o(m_write_o),
    .m_addr_o(m_addr_o), .buf_wr_o(buf_wr), .beat_o(beat),
    .busy_o(busy_o), .irq_o(irq_o), .err_o(err_o)
  );

  dma_stage_buf #(
    .BEATS(BEATS), .DATA_W(DATA_W)
  ) stage_i (
    .clk(clk), .wr_en_i(buf_wr), .wr_idx_i(beat), .wr_data_i(m_rdata_i),
    .rd_idx_i(beat), .rd_data_o(m_wdata_o)
  );

  // R12
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && m_write_o && !m_ready_i) |=> $stable(m_wdata_o));
  // R10
  busy_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && m_valid_o && trig) |=> busy_o);
endmodule

// File: tb/dma_desc_chan_tb_top.sv
module dma_desc_chan_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [6:0]  cfg_ctrl = '0;
  logic [11:0] cfg_len = '0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic        start_i = 1'b0, trig_mode_i = 1'b0, ext_req_i = 1'b0, stat_clr_i = 1'b0;
  logic        m_valid_o, m_ready_i, m_write_o, busy_o, irq_o, err_o;
  logic [31:0] m_addr_o;
  logic [63:0] m_wdata_o, m_rdata_i;

  logic [63:0] mem [64];
  logic [4:0]  lfsr = 5'h1;
  int rd_cnt = 0, wr_cnt = 0, stall_viol = 0;
  int n_checks = 0, n_err = 0;
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr = '0;
  logic [63:0] prev_wdata = '0;
  logic        prev_write = 1'b0;

  // Control coding: V=1 W=2 L=4 I=8 C=16 S=32 D=64
  localparam int NV = 5;
  localparam logic [6:0] V_CTRL [NV] = '{7'h6F, 7'h67, 7'h4F, 7'h27, 7'h0F};
  localparam int V_LEN [NV] = '{32, 64, 32, 32, 0};
  localparam int V_SRC [NV] = '{0, 64, 8, 32, 0};
  localparam int V_DST [NV] = '{256, 320, 384, 448, 256};

  always #10 clk = ~clk;

  dma_desc_chan dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_ctrl(cfg_ctrl), .cfg_len(cfg_len), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .start_i(start_i), .trig_mode_i(trig_mode_i), .ext_req_i(ext_req_i),
    .stat_clr_i(stat_clr_i), .m_valid_o(m_valid_o), .m_ready_i(m_ready_i),
    .m_write_o(m_write_o), .m_addr_o(m_addr_o), .m_wdata_o(m_wdata_o),
    .m_rdata_i(m_rdata_i), .busy_o(busy_o), .irq_o(irq_o), .err_o(err_o)
  );

  function automatic logic [63:0] pat(input int w);
    return {32'hC0DE0000 + 32'(w), ~32'(w)};
  endfunction

  assign m_ready_i = lfsr[0] | lfsr[3];
  assign m_rdata_i = mem[m_addr_o[8:3]];

  always @(posedge clk) begin
    lfsr <= {lfsr[3:0], lfsr[4] ^ lfsr[2]};
    if (m_valid_o && m_ready_i) begin
      if (m_write_o) begin
        mem[m_addr_o[8:3]] <= m_wdata_o;
        wr_cnt <= wr_cnt + 1;
      end else rd_cnt <= rd_cnt + 1;
    end
    if (prev_stall && (!m_valid_o || m_addr_o != prev_addr || m_write_o != prev_write ||
        (m_write_o && m_wdata_o != prev_wdata)))
      stall_viol <= stall_viol + 1;
    prev_stall <= m_valid_o && !m_ready_i;
    prev_addr  <= m_addr_o;
    prev_write <= m_write_o;
    prev_wdata <= m_wdata_o;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int i = 0; i < 32; i++) mem[i] = pat(i);
    for (int i = 32; i < 64; i++) mem[i] = '0;
  endtask

  task automatic load(input int idx, input logic [6:0] c, input int len, input int s, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_ctrl = c;
    cfg_len = 12'(len); cfg_src = 32'(s); cfg_dst = 32'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr_stat();
    @(negedge clk); stat_clr_i = 1'b1;
    @(negedge clk); stat_clr_i = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) check(1'b0, "watchdog busy", 64'(n), 0);
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_idle();
  endtask

  initial begin
    #4_000_000;
    check(1'b0, "watchdog global", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int r0, w0;
    init_mem();
    repeat (3) @(negedge clk);
    // R13 reset state
    check(!busy_o && !irq_o && !err_o && !m_valid_o, "R13 reset outputs",
          {busy_o, irq_o, err_o, m_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 table empty: start sees invalid entry
    pulse_start();
    check(err_o, "R13 table invalid after reset", err_o, 1);
    clr_stat();

    // Vector loop: R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      int bursts, nw, sw, dw;
      init_mem();
      load(0, V_CTRL[v], V_LEN[v], V_SRC[v], V_DST[v]);
      r0 = rd_cnt; w0 = wr_cnt;
      pulse_start();
      bursts = V_LEN[v] / 32; nw = bursts * 4;
      sw = V_SRC[v] / 8; dw = V_DST[v] / 8;
      check(wr_cnt - w0 == nw, "R9 write beats", 64'(wr_cnt - w0), 64'(nw));
      check(rd_cnt - r0 == nw, "R6 read beats", 64'(rd_cnt - r0), 64'(nw));
      if (nw > 0 && V_CTRL[v][6]) begin
        for (int j = 0; j < nw; j++) begin
          logic [63:0] e;
          e = V_CTRL[v][5] ? pat(sw + j) : pat(sw);
          check(mem[dw + j] == e, "R7 R8 dest word", mem[dw + j], e);
        end
      end else if (nw > 0) begin
        logic [63:0] e;
        e = V_CTRL[v][5] ? pat(sw + nw - 1) : pat(sw);
        check(mem[dw] == e, "R8 fixed dest final", mem[dw], e);
        check(mem[dw + 1] == 64'd0, "R8 fixed dest neighbour", mem[dw + 1], 0);
      end
      check(irq_o == V_CTRL[v][3], "R3 irq flag", irq_o, V_CTRL[v][3]);
      check(!err_o, "R1 no error on valid", err_o, 0);
      // R5 non-continuous: second start errors with no bus access
      r0 = rd_cnt; w0 = wr_cnt;
      pulse_start();
      check(err_o, "R5 valid cleared", err_o, 1);
      check(rd_cnt == r0 && wr_cnt == w0, "R1 no access on invalid",
            64'(rd_cnt - r0 + wr_cnt - w0), 0);
      clr_stat();
      check(!irq_o && !err_o, "R3 status clear", {irq_o, err_o}, 0);
    end
    check(stall_viol == 0, "R12 hold under stall", 64'(stall_viol), 0);

    // R5 R10 continuous descriptor, retrigger while busy ignored
    init_mem();
    load(0, 7'h77, 32, 0, 256);
    w0 = wr_cnt;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (3) begin
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    wait_idle();
    check(wr_cnt - w0 == 4, "R10 retrigger ignored", 64'(wr_cnt - w0), 4);
    w0 = wr_cnt;
    pulse_start();
    check(wr_cnt - w0 == 4 && !err_o, "R5 continuous reruns", 64'(wr_cnt - w0), 4);

    // R11 request-triggered mode
    trig_mode_i = 1'b1;
    w0 = wr_cnt;
    pulse_start();
    check(wr_cnt == w0 && !busy_o, "R11 start ignored in request mode", 64'(wr_cnt - w0), 0);
    @(negedge clk); ext_req_i = 1'b1;
    @(negedge clk); ext_req_i = 1'b0;
    wait_idle();
    check(wr_cnt - w0 == 4, "R11 request triggers", 64'(wr_cnt - w0), 4);
    trig_mode_i = 1'b0;
    w0 = wr_cnt;
    @(negedge clk); ext_req_i = 1'b1;
    repeat (3) @(negedge clk);
    ext_req_i = 1'b0;
    check(wr_cnt == w0, "R11 request ignored in start mode", 64'(wr_cnt - w0), 0);
    clr_stat();

    // R2 chain 0 -> 1, entry 1 wrapped; irq from entry 1 only
    init_mem();
    load(0, 7'h61, 32, 0, 256);
    load(1, 7'h6F, 32, 32, 320);
    pulse_start();
    check(mem[32] == pat(0) && mem[40] == pat(4), "R2 chain moved both",
          mem[40], pat(4));
    check(irq_o, "R3 irq from chained entry", irq_o, 1);
    clr_stat();
    // R2 after wrap, index is 0: entry 0 now invalid -> error
    pulse_start();
    check(err_o, "R2 wrap back to entry 0", err_o, 1);
    clr_stat();

    // R4 last without wrap: next start uses entry 1
    init_mem();
    load(0, 7'h65, 32, 0, 256);
    load(1, 7'h6F, 32, 64, 384);
    pulse_start();
    check(!busy_o && !irq_o && mem[48] == 64'd0, "R4 stopped after last", mem[48], 0);
    pulse_start();
    check(irq_o && mem[48] == pat(8), "R4 next start uses following entry", mem[48], pat(8));
    check(stall_viol == 0, "R12 hold under stall end", 64'(stall_viol), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule